// File: doc/BRIEF.md
# Virtual Processor Context Save/Restore Engine

This block sits inside an interrupt presenter and moves one hardware thread's operating-system interrupt context between the thread's local registers (current priority, pending-priority bits and a most-favoured-backlog byte) and a per-virtual-processor entry held in memory. A push command installs a 32-bit context word in the thread. When the word is valid, the engine fetches the entry and merges its pending bits into the thread. When automatic save/restore is enabled both globally and by the word's own flag, the engine also loads the saved priority and checks the entry out to the requesting thread. A pull command hands back the old context word, invalidates it in the thread and, under the same two conditions, writes the thread state back to the entry and checks the entry in.

Ownership of an entry is guarded in hardware. A save is refused unless the entry is valid, owned by hardware, checked out, and (when an owner is recorded) owned by the requesting thread. Entry words are written in a fixed order, so a reader never sees the ownership word change before the state word. The engine takes one command at a time, talks to memory through a simple request/acknowledge port, and ends every command with a one-cycle done strobe that carries an error flag.

Top module: `vp_ctx_engine`

## Requirements
- R1: Bits are numbered from the MSB, so "bit n" is Verilog bit 31-n. In the context word, Verilog bit 31 is valid (V), bit 30 is save/restore (H), and the low ENTRY_W bits are the entry index. An entry word is addressed as `mem_addr = {index, word}`, with word 0, 1 or 2.
- R2: Save or restore happens only when `cfg_sr_en` (sampled when the command is accepted) and H of the relevant word are both 1. Otherwise a pull makes no memory access and a push writes only the pending-bit clear of R10.
- R3: A pull returns the thread's previous context word on `rsp_ctx` and clears V (bit 31) in `trf_ctx`. A push loads `cmd_ctx` into `trf_ctx`.
- R4: A save ends with `err`=1 and no memory writes when entry word0 bit 31 (valid) is 0, word0 bit 24 (hardware-owned) is 0, or word1 bit 18 (checked out) is 0.
- R5: A save also ends with `err`=1 and no writes when word1 bit 15 (owner valid) is 1 and word1 bits 14:0 differ from `cmd_tid`.
- R6: A successful save writes word2 first, as {CPPR[31:24], IPB[23:16], LSMFB[15:8], old bits 7:0}. It then writes word1 with bit 18 cleared, bits 14:0 set to all ones and every other bit kept.
- R7: On a push with V=0, the engine reads and writes no memory and raises done with `err`=0.
- R8: On a push with V=1, the engine reports `err`=1 without writes when the entry is not valid. On a restore whose entry lacks the hardware-owned bit, it reports `err`=1, sets the thread CPPR to 0 and skips the restore writes.
- R9: A restore on a hardware-owned entry loads word2[31:24] into the thread CPPR and writes word2 with bits 31:24 zeroed. It then writes word1 with bit 18 set, bits 17:16 (privilege) set to 0, bit 15 set and bits 14:0 set to `cmd_tid`.
- R10: After a push to a valid entry, a nonzero word2[23:16] is ORed into the thread IPB, and word2 is written last with bits 23:16 cleared.
- R11: `irq` is 1 exactly when some priority p has IPB bit 7-p set and p is less than the thread CPPR.
- R12: `cmd_ready` is 1 only in idle, and only then is a command accepted. `done` is a one-cycle pulse that carries `err`. `mem_req` is held, with address, write enable and data unchanged, until `mem_ack`.
- R13: `trf_load` while idle and with no command presented sets the thread's CPPR, IPB and LSMFB from the load inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sr_en | input | 1 | Global enable for automatic save/restore |
| cmd_valid | input | 1 | Command present |
| cmd_pull | input | 1 | 1 = pull, 0 = push |
| cmd_ctx | input | 32 | Context word for a push |
| cmd_tid | input | 15 | Requesting thread ID |
| cmd_ready | output | 1 | Engine idle, command can be accepted |
| rsp_ctx | output | 32 | Previous context word returned by a pull |
| done | output | 1 | One-cycle end-of-command strobe |
| err | output | 1 | Error result of the finished command |
| mem_req | output | 1 | Entry store request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ENTRY_W+2 | Entry index and word number |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| trf_load | input | 1 | Load thread registers from the inputs below |
| trf_cppr_in | input | 8 | CPPR load value |
| trf_ipb_in | input | 8 | IPB load value |
| trf_lsmfb_in | input | 8 | LSMFB load value |
| trf_ctx | output | 32 | Thread context word register |
| trf_cppr | output | 8 | Thread current priority |
| trf_ipb | output | 8 | Thread pending-priority bits |
| trf_lsmfb | output | 8 | Thread backlog byte |
| irq | output | 1 | Pending priority is more favoured than CPPR |

## Verification
On every cycle, the assertions check the memory handshake's stability, the single-cycle done strobe, that the engine is quiet whenever it is ready, and that no write is issued outside save/restore except the final pending-bit clear. They also check that a pull really clears V, that merged pending bits are never lost, and that a failed ownership check leads straight to completion without any request. Only the bench's scenarios can show the exact contents and order of the written words, the owner-mismatch and not-hardware-owned outcomes, and the resulting priorities and interrupt line. The bench does this by comparing each command against a model of the entry store and thread registers, over directed ownership cases and random entries.

// File: rtl/vpc_pkg.sv
`timescale 1ns/1ps
package vpc_pkg;
  localparam int TID_W = 15;

  localparam int CTX_V = 31;
  localparam int CTX_H = 30;

  localparam int E0_VALID = 31;
  localparam int E0_HW    = 24;

  localparam int E1_CO    = 18;
  localparam int E1_PRIVH = 17;
  localparam int E1_PRIVL = 16;
  localparam int E1_TIDV  = 15;

  localparam int W2_CPPR_L  = 24;
  localparam int W2_IPB_L   = 16;
  localparam int W2_LSMFB_L = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_EVAL,
    ST_SV2, ST_SV1, ST_RS2, ST_RS1, ST_IPB, ST_FIN
  } vpc_state_e;

  function automatic logic [31:0] checkin_w1(input logic [31:0] w1);
    logic [31:0] r;
    r = w1;
    r[E1_CO] = 1'b0;
    r[TID_W-1:0] = '1;
    return r;
  endfunction

  function automatic logic [31:0] checkout_w1(input logic [31:0] w1,
                                              input logic [TID_W-1:0] tid);
    logic [31:0] r;
    r = w1;
    r[E1_CO] = 1'b1;
    r[E1_PRIVH:E1_PRIVL] = 2'b00;
    r[E1_TIDV] = 1'b1;
    r[TID_W-1:0] = tid;
    return r;
  endfunction
endpackage

// File: rtl/vpc_entry_chk.sv
`timescale 1ns/1ps
module vpc_entry_chk
  import vpc_pkg::*;
(
  input  logic             valid_bit,
  input  logic             hw_bit,
  input  logic             co_bit,
  input  logic             tidv_bit,
  input  logic [TID_W-1:0] owner_tid,
  input  logic [TID_W-1:0] req_tid,
  output logic             ent_valid,
  output logic             ent_hw,
  output logic             save_ok
);
  logic owner_clash;

  always_comb begin
    owner_clash = tidv_bit && (owner_tid != req_tid);
    ent_valid   = valid_bit;
    ent_hw      = hw_bit;
    save_ok     = valid_bit && hw_bit && co_bit && !owner_clash;
  end
endmodule

// File: rtl/vpc_prio_cmp.sv
`timescale 1ns/1ps
module vpc_prio_cmp #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] ipb,
  input  logic [PRIO_W-1:0] cppr,
  output logic              irq
);
  logic [PRIO_W-1:0] best;
  logic              any;

  always_comb begin
    best = '0;
    any  = 1'b0;
    for (int p = PRIO_W-1; p >= 0; p--) begin
      if (ipb[PRIO_W-1-p]) begin
        best = PRIO_W'(p);
        any  = 1'b1;
      end
    end
    irq = any && (best < cppr);
  end
endmodule

// File: rtl/vpc_thread_regs.sv
`timescale 1ns/1ps
module vpc_thread_regs
  import vpc_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctx_we,
  input  logic [31:0]       ctx_d,
  input  logic              v_clr,
  input  logic              load_we,
  input  logic [PRIO_W-1:0] load_cppr,
  input  logic [PRIO_W-1:0] load_ipb,
  input  logic [PRIO_W-1:0] load_lsmfb,
  input  logic              cppr_we,
  input  logic [PRIO_W-1:0] cppr_d,
  input  logic              ipb_or_we,
  input  logic [PRIO_W-1:0] ipb_or_d,
  output logic [31:0]       ctx_q,
  output logic [PRIO_W-1:0] cppr_q,
  output logic [PRIO_W-1:0] ipb_q,
  output logic [PRIO_W-1:0] lsmfb_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q   <= '0;
      cppr_q  <= '0;
      ipb_q   <= '0;
      lsmfb_q <= '0;
    end else begin
      if (ctx_we) begin
        ctx_q <= ctx_d;
      end else if (v_clr) begin
        ctx_q[CTX_V] <= 1'b0;
      end
      if (load_we) begin
        cppr_q <= load_cppr;
      end else if (cppr_we) begin
        cppr_q <= cppr_d;
      end
      if (load_we) begin
        ipb_q <= load_ipb;
      end else if (ipb_or_we) begin
        ipb_q <= ipb_q | ipb_or_d;
      end
      if (load_we) begin
        lsmfb_q <= load_lsmfb;
      end
    end
  end

  // R3: a pull leaves the context word invalid
  a_r3_v_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    v_clr |=> !ctx_q[CTX_V]);

  // R10: merged pending bits are all present afterwards
  a_r10_ipb_merged: assert property (@(posedge clk) disable iff (!rst_n)
    (ipb_or_we && !load_we) |=> ((ipb_q & $past(ipb_or_d)) == $past(ipb_or_d)));
endmodule

// File: rtl/vp_ctx_engine.sv
`timescale 1ns/1ps
module vp_ctx_engine
  import vpc_pkg::*;
#(
  parameter  int ENTRY_W = 20,
  localparam int ADDR_W  = ENTRY_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sr_en,
  input  logic              cmd_valid,
  input  logic              cmd_pull,
  input  logic [31:0]       cmd_ctx,
  input  logic [TID_W-1:0]  cmd_tid,
  output logic              cmd_ready,
  output logic [31:0]       rsp_ctx,
  output logic              done,
  output logic              err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              trf_load,
  input  logic [7:0]        trf_cppr_in,
  input  logic [7:0]        trf_ipb_in,
  input  logic [7:0]        trf_lsmfb_in,
  output logic [31:0]       trf_ctx,
  output logic [7:0]        trf_cppr,
  output logic [7:0]        trf_ipb,
  output logic [7:0]        trf_lsmfb,
  output logic              irq
);
  localparam int PRIO_W = 8;

  vpc_state_e         state_q, state_d;
  logic               op_pull_q, sr_q;
  logic [ENTRY_W-1:0] idx_q;
  logic [TID_W-1:0]   tid_q;
  logic [1:0]         w0_q;
  logic [31:0]        w1_q, w2_q, rsp_q;
  logic               err_q;

  logic        accept, v_clr, ctx_we, rsp_we, load_we;
  logic        w0_we, w1_we, w2_we, w2_cppr_clr, err_set;
  logic        cppr_we, ipb_or_we;
  logic [7:0]  cppr_d;
  logic [31:0] sel_ctx;
  logic        ent_valid, ent_hw, save_ok, ipb_pend;
  logic [1:0]  word_sel;

  assign sel_ctx  = cmd_pull ? trf_ctx : cmd_ctx;
  assign ipb_pend = |w2_q[W2_IPB_L +: PRIO_W];

  vpc_entry_chk u_chk (
    .valid_bit (w0_q[1]),
    .hw_bit    (w0_q[0]),
    .co_bit    (w1_q[E1_CO]),
    .tidv_bit  (w1_q[E1_TIDV]),
    .owner_tid (w1_q[TID_W-1:0]),
    .req_tid   (tid_q),
    .ent_valid (ent_valid),
    .ent_hw    (ent_hw),
    .save_ok   (save_ok)
  );

  vpc_thread_regs #(.PRIO_W(PRIO_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctx_we     (ctx_we),
    .ctx_d      (cmd_ctx),
    .v_clr      (v_clr),
    .load_we    (load_we),
    .load_cppr  (trf_cppr_in),
    .load_ipb   (trf_ipb_in),
    .load_lsmfb (trf_lsmfb_in),
    .cppr_we    (cppr_we),
    .cppr_d     (cppr_d),
    .ipb_or_we  (ipb_or_we),
    .ipb_or_d   (w2_q[W2_IPB_L +: PRIO_W]),
    .ctx_q      (trf_ctx),
    .cppr_q     (trf_cppr),
    .ipb_q      (trf_ipb),
    .lsmfb_q    (trf_lsmfb)
  );

  vpc_prio_cmp #(.PRIO_W(PRIO_W)) u_prio (
    .ipb  (trf_ipb),
    .cppr (trf_cppr),
    .irq  (irq)
  );

  // next-state and control
  always_comb begin
    state_d     = state_q;
    accept      = 1'b0;
    v_clr       = 1'b0;
    ctx_we      = 1'b0;
    rsp_we      = 1'b0;
    w0_we       = 1'b0;
    w1_we       = 1'b0;
    w2_we       = 1'b0;
    w2_cppr_clr = 1'b0;
    err_set     = 1'b0;
    cppr_we     = 1'b0;
    cppr_d      = '0;
    ipb_or_we   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          accept = 1'b1;
          if (cmd_pull) begin
            v_clr   = 1'b1;
            rsp_we  = 1'b1;
            state_d = (cfg_sr_en && trf_ctx[CTX_H]) ? ST_RD0 : ST_FIN;
          end else begin
            ctx_we  = 1'b1;
            state_d = cmd_ctx[CTX_V] ? ST_RD0 : ST_FIN;
          end
        end
      end
      ST_RD0: if (mem_ack) begin w0_we = 1'b1; state_d = ST_RD1; end
      ST_RD1: if (mem_ack) begin w1_we = 1'b1; state_d = ST_RD2; end
      ST_RD2: if (mem_ack) begin w2_we = 1'b1; state_d = ST_EVAL; end
      ST_EVAL: begin
        if (op_pull_q) begin
          if (save_ok) begin
            state_d = ST_SV2;
          end else begin
            err_set = 1'b1;
            state_d = ST_FIN;
          end
        end else if (!ent_valid) begin
          err_set = 1'b1;
          state_d = ST_FIN;
        end else if (sr_q && ent_hw) begin
          cppr_we = 1'b1;
          cppr_d  = w2_q[W2_CPPR_L +: PRIO_W];
          state_d = ST_RS2;
        end else begin
          if (sr_q) begin
            err_set = 1'b1;
            cppr_we = 1'b1;
          end
          if (ipb_pend) begin
            ipb_or_we = 1'b1;
            state_d   = ST_IPB;
          end else begin
            state_d = ST_FIN;
          end
        end
      end
      ST_SV2: if (mem_ack) state_d = ST_SV1;
      ST_SV1: if (mem_ack) state_d = ST_FIN;
      ST_RS2: if (mem_ack) begin w2_cppr_clr = 1'b1; state_d = ST_RS1; end
      ST_RS1: begin
        if (mem_ack) begin
          if (ipb_pend) begin
            ipb_or_we = 1'b1;
            state_d   = ST_IPB;
          end else begin
            state_d = ST_FIN;
          end
        end
      end
      ST_IPB:  if (mem_ack) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign load_we = trf_load && (state_q == ST_IDLE) && !cmd_valid;

  // memory port
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    word_sel  = 2'd0;
    mem_wdata = '0;
    unique case (state_q)
      ST_RD0: begin mem_req = 1'b1; word_sel = 2'd0; end
      ST_RD1: begin mem_req = 1'b1; word_sel = 2'd1; end
      ST_RD2: begin mem_req = 1'b1; word_sel = 2'd2; end
      ST_SV2: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        word_sel  = 2'd2;
        mem_wdata = {trf_cppr, trf_ipb, trf_lsmfb, w2_q[7:0]};
      end
      ST_SV1: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        word_sel  = 2'd1;
        mem_wdata = checkin_w1(w1_q);
      end
      ST_RS2: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        word_sel  = 2'd2;
        mem_wdata = {8'h00, w2_q[23:0]};
      end
      ST_RS1: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        word_sel  = 2'd1;
        mem_wdata = checkout_w1(w1_q, tid_q);
      end
      ST_IPB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        word_sel  = 2'd2;
        mem_wdata = {w2_q[31:24], 8'h00, w2_q[15:0]};
      end
      default: begin end
    endcase
  end

  assign mem_addr  = {idx_q, word_sel};
  assign cmd_ready = (state_q == ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign err       = err_q;
  assign rsp_ctx   = rsp_q;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      op_pull_q <= 1'b0;
      sr_q      <= 1'b0;
      idx_q     <= '0;
      tid_q     <= '0;
      w0_q      <= '0;
      w1_q      <= '0;
      w2_q      <= '0;
      rsp_q     <= '0;
      err_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_pull_q <= cmd_pull;
        sr_q      <= cfg_sr_en && sel_ctx[CTX_H];
        idx_q     <= sel_ctx[ENTRY_W-1:0];
        tid_q     <= cmd_tid;
      end
      if (rsp_we) rsp_q <= trf_ctx;
      if (w0_we)  w0_q  <= {mem_rdata[E0_VALID], mem_rdata[E0_HW]};
      if (w1_we)  w1_q  <= mem_rdata;
      if (w2_we) begin
        w2_q <= mem_rdata;
      end else if (w2_cppr_clr) begin
        w2_q[W2_CPPR_L +: PRIO_W] <= '0;
      end
      if (accept) begin
        err_q <= 1'b0;
      end else if (err_set) begin
        err_q <= 1'b1;
      end
    end
  end

  // R12: request held stable until acknowledged
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  // R12: done lasts one cycle
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12: no memory traffic while ready
  a_r12_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req);

  // R2: outside save/restore the only write is the pending-bit clear
  a_r2_plain_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !sr_q) |-> (state_q == ST_IPB));

  // R4 R5: a refused save completes without any request
  a_r4_refused_save: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EVAL && op_pull_q && !save_ok) |=> (done && !mem_req && err));
endmodule

// File: tb/vp_ctx_engine_tb_top.sv
`timescale 1ns/1ps
module vp_ctx_engine_tb_top;
  localparam int EW = 20;
  localparam int AW = EW + 2;

  logic clk, rst_n;
  logic cfg_sr_en, cmd_valid, cmd_pull;
  logic [31:0] cmd_ctx;
  logic [14:0] cmd_tid;
  logic cmd_ready, done, err, mem_req, mem_we, mem_ack, irq;
  logic [31:0] rsp_ctx, mem_wdata, mem_rdata, trf_ctx;
  logic [AW-1:0] mem_addr;
  logic trf_load;
  logic [7:0] trf_cppr_in, trf_ipb_in, trf_lsmfb_in, trf_cppr, trf_ipb, trf_lsmfb;

  vp_ctx_engine #(.ENTRY_W(EW)) dut_i (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] mem [64];
  logic [31:0] ref_mem [64];
  logic [AW-1:0] wr_log [256];
  int wr_total;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[5:0]] <= mem_wdata;
        wr_log[wr_total[7:0]] <= mem_addr;
        wr_total <= wr_total + 1;
      end else begin
        mem_rdata <= mem[mem_addr[5:0]];
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  int n_chk, n_bad;
  logic [31:0] m_ctx;
  logic [7:0] m_cppr, m_ipb, m_lsmfb;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic exp_irq(input logic [7:0] ipb, input logic [7:0] cppr);
    for (int p = 0; p < 8; p++) if (ipb[7-p]) return (8'(p) < cppr);
    return 1'b0;
  endfunction

  task automatic set_entry(input int idx, input logic [31:0] w0, w1, w2);
    mem[idx*4] = w0; mem[idx*4+1] = w1; mem[idx*4+2] = w2;
    ref_mem[idx*4] = w0; ref_mem[idx*4+1] = w1; ref_mem[idx*4+2] = w2;
  endtask

  task automatic load_thread(input logic [7:0] c, i, l);
    @(negedge clk);
    trf_load = 1'b1; trf_cppr_in = c; trf_ipb_in = i; trf_lsmfb_in = l;
    @(negedge clk);
    trf_load = 1'b0;
    m_cppr = c; m_ipb = i; m_lsmfb = l;
    check("R13 load cppr", {24'h0, trf_cppr}, {24'h0, c});
    check("R13 load ipb", {24'h0, trf_ipb}, {24'h0, i});
    check("R13 load lsmfb", {24'h0, trf_lsmfb}, {24'h0, l});
  endtask

  task automatic run_cmd(input logic pull, input logic [31:0] ctx, input logic [14:0] tid,
                         input logic en);
    logic [31:0] old, w0, w1, w2, exp_rsp;
    logic [AW-1:0] exp_addr [4];
    int exp_n, idx, base, cnt;
    logic exp_err;
    exp_err = 1'b0; exp_n = 0; exp_rsp = '0;
    old = m_ctx;
    idx = pull ? int'(old[3:0]) : int'(ctx[3:0]);
    w0 = ref_mem[idx*4]; w1 = ref_mem[idx*4+1]; w2 = ref_mem[idx*4+2];
    if (pull) begin
      exp_rsp = old;
      m_ctx[31] = 1'b0;
      if (en && old[30]) begin
        if (!w0[31] || !w0[24] || !w1[18] || (w1[15] && w1[14:0] != tid)) begin
          exp_err = 1'b1;
        end else begin
          w2 = {m_cppr, m_ipb, m_lsmfb, w2[7:0]};
          ref_mem[idx*4+2] = w2; exp_addr[exp_n] = AW'(idx*4+2); exp_n++;
          w1[18] = 1'b0; w1[14:0] = '1;
          ref_mem[idx*4+1] = w1; exp_addr[exp_n] = AW'(idx*4+1); exp_n++;
        end
      end
    end else begin
      m_ctx = ctx;
      if (ctx[31]) begin
        if (!w0[31]) begin
          exp_err = 1'b1;
        end else begin
          if (en && ctx[30]) begin
            if (w0[24]) begin
              m_cppr = w2[31:24];
              w2[31:24] = 8'h00;
              ref_mem[idx*4+2] = w2; exp_addr[exp_n] = AW'(idx*4+2); exp_n++;
              w1[18] = 1'b1; w1[17:16] = 2'b00; w1[15] = 1'b1; w1[14:0] = tid;
              ref_mem[idx*4+1] = w1; exp_addr[exp_n] = AW'(idx*4+1); exp_n++;
            end else begin
              exp_err = 1'b1;
              m_cppr = 8'h00;
            end
          end
          if (w2[23:16] != 8'h00) begin
            m_ipb = m_ipb | w2[23:16];
            w2[23:16] = 8'h00;
            ref_mem[idx*4+2] = w2; exp_addr[exp_n] = AW'(idx*4+2); exp_n++;
          end
        end
      end
    end

    @(negedge clk);
    cfg_sr_en = en;
    check("R12 ready before command", {31'h0, cmd_ready}, 32'h1);
    base = wr_total;
    cmd_valid = 1'b1; cmd_pull = pull; cmd_ctx = ctx; cmd_tid = tid;
    @(negedge clk);
    cmd_valid = 1'b0;
    cnt = 0;
    while (!done && cnt < 200) begin
      @(negedge clk);
      cnt++;
    end
    check("R12 done seen", {31'h0, done}, 32'h1);
    check("R4 R5 R8 err flag", {31'h0, err}, {31'h0, exp_err});
    check("R3 thread ctx", trf_ctx, m_ctx);
    check("R9 thread cppr", {24'h0, trf_cppr}, {24'h0, m_cppr});
    check("R10 thread ipb", {24'h0, trf_ipb}, {24'h0, m_ipb});
    check("R6 thread lsmfb", {24'h0, trf_lsmfb}, {24'h0, m_lsmfb});
    check("R11 irq", {31'h0, irq}, {31'h0, exp_irq(m_ipb, m_cppr)});
    if (pull) check("R3 returned word", rsp_ctx, exp_rsp);
    check("R2 R7 write count", 32'(wr_total - base), 32'(exp_n));
    for (int k = 0; k < exp_n && k < 4; k++)
      check("R1 R6 R9 write order", 32'(wr_log[(base + k) % 256]), 32'(exp_addr[k]));
    for (int k = 0; k < 3; k++)
      check("R6 R9 R10 entry word", mem[idx*4+k], ref_mem[idx*4+k]);
    @(negedge clk);
    check("R12 done pulse ends", {31'h0, done}, 32'h0);
  endtask

  initial begin
    int watchdog;
    watchdog = 0;
    forever begin
      @(posedge clk);
      watchdog++;
      if (watchdog > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected below 150000", watchdog);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] r;
    n_chk = 0; n_bad = 0; wr_total = 0;
    m_ctx = '0; m_cppr = '0; m_ipb = '0; m_lsmfb = '0;
    rst_n = 1'b0; cfg_sr_en = 1'b1; cmd_valid = 1'b0; cmd_pull = 1'b0;
    cmd_ctx = '0; cmd_tid = '0; trf_load = 1'b0;
    trf_cppr_in = '0; trf_ipb_in = '0; trf_lsmfb_in = '0; mem_rdata = '0;
    for (int i = 0; i < 64; i++) begin mem[i] = '0; ref_mem[i] = '0; end
    r = $urandom(32'd20211126);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset ready", {31'h0, cmd_ready}, 32'h1);
    check("R12 reset done", {31'h0, done}, 32'h0);
    check("R12 reset mem_req", {31'h0, mem_req}, 32'h0);
    check("R3 reset ctx", trf_ctx, 32'h0);
    check("R11 reset irq", {31'h0, irq}, 32'h0);

    // directed: restore, then save, then refused save
    set_entry(3, 32'h8100_0000, 32'h0000_0000, 32'h0320_115A);
    load_thread(8'hFF, 8'h01, 8'h44);
    run_cmd(1'b0, 32'hC000_0003, 15'd7, 1'b1);   // R9 R10 R11
    run_cmd(1'b1, 32'h0, 15'd7, 1'b1);           // R6 R3
    run_cmd(1'b1, 32'h0, 15'd7, 1'b1);           // R4 not checked out
    // owner mismatch
    set_entry(5, 32'h8100_0000, 32'h0000_0000, 32'h0500_0000);
    run_cmd(1'b0, 32'hC000_0005, 15'd9, 1'b1);
    run_cmd(1'b1, 32'h0, 15'd2, 1'b1);           // R5
    // invalid entry push and not hardware-owned restore
    set_entry(6, 32'h0000_0000, 32'h0004_0000, 32'h0110_0000);
    run_cmd(1'b0, 32'hC000_0006, 15'd1, 1'b1);   // R8
    set_entry(7, 32'h8000_0000, 32'h0000_0000, 32'h2280_0000);
    load_thread(8'h10, 8'h00, 8'h00);
    run_cmd(1'b0, 32'hC000_0007, 15'd1, 1'b1);   // R8 cppr 0
    // V clear push and disabled save
    run_cmd(1'b0, 32'h4000_0008, 15'd1, 1'b1);   // R7
    set_entry(9, 32'h8104_0000, 32'h0004_0000, 32'h0000_0000);
    run_cmd(1'b0, 32'hC000_0009, 15'd3, 1'b0);
    run_cmd(1'b1, 32'h0, 15'd3, 1'b0);           // R2 plain pull

    // random
    for (int it = 0; it < 400; it++) begin
      int idx;
      logic [31:0] w0, w1, w2, ctx;
      idx = int'($urandom_range(0, 15));
      if ($urandom_range(0, 2) == 0) begin
        w0 = $urandom;
        w0[31] = ($urandom_range(0, 99) < 85);
        w0[24] = ($urandom_range(0, 99) < 85);
        w1 = $urandom;
        w1[18] = ($urandom_range(0, 99) < 75);
        if ($urandom_range(0, 1) == 1) w1[14:0] = 15'($urandom_range(0, 3));
        w2 = $urandom;
        if ($urandom_range(0, 2) == 0) w2[23:16] = 8'h00;
        set_entry(idx, w0, w1, w2);
      end
      if ($urandom_range(0, 9) == 0)
        load_thread(8'($urandom), 8'($urandom), 8'($urandom));
      ctx = $urandom;
      ctx[19:4] = '0;
      ctx[3:0] = 4'(idx);
      ctx[31] = ($urandom_range(0, 99) < 85);
      ctx[30] = ($urandom_range(0, 99) < 70);
      run_cmd(1'($urandom_range(0, 1)), ctx, 15'($urandom_range(0, 3)),
              ($urandom_range(0, 99) < 85));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule